// File: doc/BRIEF.md
# LCD Pixel Format Unpacker

The unpacker sits between the frame-buffer fetch path and the palette/output stage of an LCD controller. It accepts one 32-bit word of frame-buffer data at a time. It then emits the pixels packed in that word, one per cycle, with a valid/ready handshake on both sides. For depths of 8 bits or less it emits a palette index. For the direct-colour depths it emits 8-bit red, green and blue components, each expanded from its packed field.

The configuration inputs are:
- the layout inputs: a depth code, a red/blue swap bit, two big-endian ordering bits and a 2-bit external layout-mux code;
- a variant flag that marks whether 565 and 444 are native depth codes;
- an enable bit and a power bit.

The unpacker also computes, from a column count and the depth code, how many source bytes one display line occupies.

Top module: `pxl_unpack`

## Requirements
- R1: Pixels flow only while `ctl_en` and `ctl_power` are both 1 and the depth code is legal. Codes 6 and 7 are legal only when `native565` is 1. While this is not the case, `in_ready` and `out_valid` are 0, and any word being unpacked is discarded.
- R2: A word is unpacked into 32/W pixels. W is 1, 2, 4, 8, 16 or 32 for codes 0 to 5, and 16 for codes 6 and 7. After the last pixel is taken, `out_valid` is 0 and `in_ready` is 1 in the next cycle.
- R3: A word accepted at a clock edge shows its first pixel with `out_valid` high in the following cycle. While `out_ready` is 0, the same pixel is held and no new word is accepted.
- R4: With both ordering bits clear, pixel k of a word is taken from bits [k*W +: W].
- R5: With `ctl_be_byte` set, pixel k is taken from bits [32-(k+1)*W +: W]. This holds whatever the value of `ctl_be_pix`.
- R6: With only `ctl_be_pix` set and W below 8, bytes are used from the least significant byte upward, and the pixels inside each byte are used from its most significant end. For W of 8 or more, the bit has no effect.
- R7: For codes 0 to 3, `out_indexed` is 1, `out_index` holds the pixel value (zero-extended) and the colour outputs are 0. For the other codes, `out_indexed` and `out_index` are 0.
- R8: In 565 layout, red is p[4:0]<<3, green is p[10:5]<<2 and blue is p[15:11]<<3. `ctl_bgr` exchanges red and blue.
- R9: In 5551 layout, red is p[4:0]<<3, green is p[9:5]<<3 and blue is p[14:10]<<3. Bit 15 is ignored, and `ctl_bgr` exchanges red and blue.
- R10: Code 4 with `native565`=0 takes its layout from `mux_sel`:
  - 1 selects 5551;
  - 3 selects 565 with red and blue always exchanged;
  - 0 or 2 select 565 with `ctl_bgr` honoured.

  With `native565`=1, code 4 is 5551 whatever `mux_sel` holds, and code 6 is 565.
- R11: Code 7 (444 layout) gives red p[3:0]<<4, green p[7:4]<<4 and blue p[11:8]<<4. Bits 15:12 are ignored, and `ctl_bgr` exchanges red and blue.
- R12: Code 5 gives red from w[7:0], green from w[15:8] and blue from w[23:16]. The top byte is ignored, and `ctl_bgr` exchanges red and blue.
- R13: `line_bytes` equals `line_cols` divided by 8, 4 or 2 for codes 0, 1 and 2. It equals `line_cols` for code 3, twice `line_cols` for codes 4, 6 and 7, and four times `line_cols` for code 5. It is combinational.
- R14: After reset, no word is held: `out_valid` is 0, and `in_ready` is 1 when the configuration is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_en | input | 1 | Enable bit (control bit 0) |
| ctl_power | input | 1 | Power bit (control bit 11) |
| ctl_depth | input | 3 | Depth code (control bits 3:1) |
| ctl_bgr | input | 1 | Red/blue exchange (control bit 8) |
| ctl_be_byte | input | 1 | Big-endian byte order (control bit 9) |
| ctl_be_pix | input | 1 | Big-endian pixel order inside bytes (control bit 10) |
| mux_sel | input | 2 | External 16-bit layout selector |
| native565 | input | 1 | Variant with native 565/444 codes |
| line_cols | input | COL_W | Columns per line |
| line_bytes | output | COL_W+2 | Source bytes per line |
| in_valid | input | 1 | Word available |
| in_ready | output | 1 | Word can be taken |
| in_word | input | 32 | Frame-buffer word |
| out_valid | output | 1 | Pixel available |
| out_ready | input | 1 | Pixel taken |
| out_indexed | output | 1 | Pixel is a palette index |
| out_index | output | 8 | Palette index |
| out_r | output | 8 | Red |
| out_g | output | 8 | Green |
| out_b | output | 8 | Blue |

## Verification
The unpacker has one register stage between the two handshakes. The first pixel of a word is due in the cycle after the edge that accepts the word. Each later pixel is due one cycle after the previous one is taken, and `in_ready` returns one cycle after the last pixel is taken. `line_bytes` and the disabled-state gating of the handshakes are combinational, so they are due in the same cycle as their inputs.

The bench drives inputs and samples outputs on the falling edge. After an accepting rising edge, it reads the first pixel at the next falling edge, and then reads one pixel per falling edge while `out_ready` stays high. It checks the free state at the falling edge after the last pixel.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

  localparam int WORD_W = 32;
  localparam int SLOT_W = 5;

  typedef enum logic [2:0] {
    DEP_1B  = 3'd0,
    DEP_2B  = 3'd1,
    DEP_4B  = 3'd2,
    DEP_8B  = 3'd3,
    DEP_16B = 3'd4,
    DEP_32B = 3'd5,
    DEP_565 = 3'd6,
    DEP_444 = 3'd7
  } depth_e;

  typedef enum logic [2:0] {
    FMT_INDEX,
    FMT_5551,
    FMT_565,
    FMT_444,
    FMT_888
  } fmt_e;

  typedef struct packed {
    fmt_e              fmt;
    logic              swap_rb;
    logic              be_byte;
    logic              be_pix;
    logic [2:0]        lw;        // log2 of pixel width
    logic [SLOT_W-1:0] last_slot; // pixels per word minus one
  } mode_t;

  function automatic logic [2:0] depth_lw(depth_e d);
    case (d)
      DEP_1B:  return 3'd0;
      DEP_2B:  return 3'd1;
      DEP_4B:  return 3'd2;
      DEP_8B:  return 3'd3;
      DEP_32B: return 3'd5;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [SLOT_W-1:0] lw_last_slot(logic [2:0] lw);
    logic [5:0] cnt;
    cnt = 6'd32 >> lw;
    return SLOT_W'(cnt - 6'd1);
  endfunction

  // Bit offset of pixel k: linear offset k*W, reflected inside the word
  // (byte order) or inside a byte (pixel order). W is a power of two,
  // so the reflection is an XOR with (span - W).
  function automatic logic [5:0] slot_shift(logic [SLOT_W-1:0] k, logic [2:0] lw,
                                            logic be_byte, logic be_pix);
    logic [5:0] lin;
    logic [5:0] w;
    lin = {1'b0, k} << lw;
    w   = 6'd1 << lw;
    if (be_byte)
      return lin ^ (6'd32 - w);
    else if (be_pix && (lw < 3'd3))
      return lin ^ (6'd8 - w);
    else
      return lin;
  endfunction

  function automatic logic [23:0] slot_value(logic [WORD_W-1:0] word, logic [5:0] sh,
                                             logic [2:0] lw);
    logic [WORD_W-1:0] s;
    logic [WORD_W-1:0] m;
    s = word >> sh;
    m = ~({WORD_W{1'b1}} << (6'd1 << lw));
    return s[23:0] & m[23:0];
  endfunction

  function automatic logic [7:0] widen4(logic [3:0] x);
    return {x, 4'b0000};
  endfunction

  function automatic logic [7:0] widen5(logic [4:0] x);
    return {x, 3'b000};
  endfunction

  function automatic logic [7:0] widen6(logic [5:0] x);
    return {x, 2'b00};
  endfunction

endpackage

// File: rtl/pxu_decode.sv
module pxu_decode
  import pxu_pkg::*;
#(
  parameter int COL_W = 12,
  localparam int LB_W = COL_W + 2
) (
  input  logic             en,
  input  logic             pwr,
  input  logic [2:0]       depth,
  input  logic             bgr,
  input  logic             be_byte,
  input  logic             be_pix,
  input  logic [1:0]       mux_sel,
  input  logic             native565,
  input  logic [COL_W-1:0] cols,
  output mode_t            mode,
  output logic             active,
  output logic [LB_W-1:0]  line_bytes
);

  depth_e d;
  logic   code_ok;

  assign d       = depth_e'(depth);
  assign code_ok = native565 || (d != DEP_565 && d != DEP_444);
  assign active  = en && pwr && code_ok;

  function automatic logic [LB_W-1:0] bytes_per_line(depth_e dd, logic [COL_W-1:0] c);
    logic [LB_W-1:0] ext;
    ext = {2'b00, c};
    case (dd)
      DEP_1B:  return ext >> 3;
      DEP_2B:  return ext >> 2;
      DEP_4B:  return ext >> 1;
      DEP_8B:  return ext;
      DEP_32B: return ext << 2;
      default: return ext << 1;
    endcase
  endfunction

  assign line_bytes = bytes_per_line(d, cols);

  always_comb begin
    mode.lw        = depth_lw(d);
    mode.last_slot = lw_last_slot(mode.lw);
    mode.be_byte   = be_byte;
    mode.be_pix    = be_pix && !be_byte;
    mode.swap_rb   = bgr;
    case (d)
      DEP_32B: mode.fmt = FMT_888;
      DEP_565: mode.fmt = FMT_565;
      DEP_444: mode.fmt = FMT_444;
      DEP_16B: begin
        if (native565 || mux_sel == 2'd1) begin
          mode.fmt = FMT_5551;
        end else begin
          mode.fmt = FMT_565;
          if (mux_sel == 2'd3) mode.swap_rb = 1'b1;
        end
      end
      default: mode.fmt = FMT_INDEX;
    endcase
  end

endmodule

// File: rtl/pxu_slicer.sv
module pxu_slicer
  import pxu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [SLOT_W-1:0] last_slot,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] word_q,
  output logic [SLOT_W-1:0] slot_q
);

  logic full_q;
  logic load_evt;
  logic adv_evt;
  logic last_evt;

  assign in_ready  = active && !full_q;
  assign out_valid = active && full_q;
  assign load_evt  = in_valid && in_ready;
  assign adv_evt   = out_valid && out_ready;
  assign last_evt  = adv_evt && (slot_q == last_slot);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      slot_q <= '0;
      word_q <= '0;
    end else if (!active) begin
      full_q <= 1'b0;
    end else if (load_evt) begin
      full_q <= 1'b1;
      slot_q <= '0;
      word_q <= in_word;
    end else if (last_evt) begin
      full_q <= 1'b0;
    end else if (adv_evt) begin
      slot_q <= slot_q + 1'b1;
    end
  end

  assert_load_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (full_q && slot_q == '0));

  assert_stall_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && active && !out_ready) |=> (full_q && $stable(slot_q)));

  assert_word_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |=> $stable(word_q));

  assert_last_frees_R2: assert property (@(posedge clk) disable iff (!rst_n)
    last_evt |=> !full_q);

  assert_off_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !full_q);

endmodule

// File: rtl/pxu_colour.sv
module pxu_colour
  import pxu_pkg::*;
(
  input  mode_t       mode,
  input  logic [23:0] pix,
  output logic        indexed,
  output logic [7:0]  index,
  output logic [7:0]  r,
  output logic [7:0]  g,
  output logic [7:0]  b
);

  logic [7:0] lo_c;
  logic [7:0] hi_c;

  always_comb begin
    indexed = 1'b0;
    index   = 8'h00;
    lo_c    = 8'h00;
    g       = 8'h00;
    hi_c    = 8'h00;
    case (mode.fmt)
      FMT_INDEX: begin
        indexed = 1'b1;
        index   = pix[7:0];
      end
      FMT_5551: begin
        lo_c = widen5(pix[4:0]);
        g    = widen5(pix[9:5]);
        hi_c = widen5(pix[14:10]);
      end
      FMT_565: begin
        lo_c = widen5(pix[4:0]);
        g    = widen6(pix[10:5]);
        hi_c = widen5(pix[15:11]);
      end
      FMT_444: begin
        lo_c = widen4(pix[3:0]);
        g    = widen4(pix[7:4]);
        hi_c = widen4(pix[11:8]);
      end
      FMT_888: begin
        lo_c = pix[7:0];
        g    = pix[15:8];
        hi_c = pix[23:16];
      end
      default: ;
    endcase
    r = mode.swap_rb ? hi_c : lo_c;
    b = mode.swap_rb ? lo_c : hi_c;
  end

endmodule

// File: rtl/pxl_unpack.sv
module pxl_unpack
  import pxu_pkg::*;
#(
  parameter int COL_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_en,
  input  logic               ctl_power,
  input  logic [2:0]         ctl_depth,
  input  logic               ctl_bgr,
  input  logic               ctl_be_byte,
  input  logic               ctl_be_pix,
  input  logic [1:0]         mux_sel,
  input  logic               native565,
  input  logic [COL_W-1:0]   line_cols,
  output logic [COL_W+1:0]   line_bytes,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [31:0]        in_word,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_indexed,
  output logic [7:0]         out_index,
  output logic [7:0]         out_r,
  output logic [7:0]         out_g,
  output logic [7:0]         out_b
);

  mode_t             mode;
  logic              active_w;
  logic [WORD_W-1:0] word_q;
  logic [SLOT_W-1:0] slot_q;
  logic [5:0]        shift_w;
  logic [23:0]       pix_w;

  pxu_decode #(.COL_W(COL_W)) u_decode (
    .en         (ctl_en),
    .pwr        (ctl_power),
    .depth      (ctl_depth),
    .bgr        (ctl_bgr),
    .be_byte    (ctl_be_byte),
    .be_pix     (ctl_be_pix),
    .mux_sel    (mux_sel),
    .native565  (native565),
    .cols       (line_cols),
    .mode       (mode),
    .active     (active_w),
    .line_bytes (line_bytes)
  );

  pxu_slicer u_slicer (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active_w),
    .last_slot (mode.last_slot),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_word   (in_word),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .word_q    (word_q),
    .slot_q    (slot_q)
  );

  assign shift_w = slot_shift(slot_q, mode.lw, mode.be_byte, mode.be_pix);
  assign pix_w   = slot_value(word_q, shift_w, mode.lw);

  pxu_colour u_colour (
    .mode    (mode),
    .pix     (pix_w),
    .indexed (out_indexed),
    .index   (out_index),
    .r       (out_r),
    .g       (out_g),
    .b       (out_b)
  );

  assert_index_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_indexed |-> (out_r == 8'h00 && out_g == 8'h00 && out_b == 8'h00));

  assert_bad_code_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!native565 && ctl_depth[2:1] == 2'b11) |-> (!in_ready && !out_valid));

  assert_colour_no_index_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_indexed |-> (out_index == 8'h00));

endmodule

// File: tb/test_pxl_unpack.sv
`timescale 1ns/1ps
module test_pxl_unpack;

  localparam int COL_W = 12;
  localparam int NV    = 22;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ctl_en = 1'b1, ctl_power = 1'b1;
  logic [2:0]       ctl_depth = 3'd3;
  logic             ctl_bgr = 1'b0, ctl_be_byte = 1'b0, ctl_be_pix = 1'b0;
  logic [1:0]       mux_sel = 2'd0;
  logic             native565 = 1'b0;
  logic [COL_W-1:0] line_cols = '0;
  logic [COL_W+1:0] line_bytes;
  logic             in_valid = 1'b0, in_ready;
  logic [31:0]      in_word = '0;
  logic             out_valid, out_ready = 1'b0;
  logic             out_indexed;
  logic [7:0]       out_index, out_r, out_g, out_b;

  always #2.5 clk = ~clk;

  pxl_unpack #(.COL_W(COL_W)) i_pxl_unpack (.*);

  int checks = 0;
  int fails  = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  dep;
    logic        bgr, bb, bp;
    logic [1:0]  mux;
    logic        nat;
    logic [31:0] word;
    logic [4:0]  k;
    logic        ind;
    logic [7:0]  idx, r, g, b;
  } vec_t;

  // req, dep, bgr, bb, bp, mux, nat, word, k, ind, idx, r, g, b
  localparam vec_t VECS [NV] = '{
    '{4'd4,  3'd3, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 32'h44332211, 5'd2, 1'b1, 8'h33, 8'h00, 8'h00, 8'h00}, // R4
    '{4'd5,  3'd3, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 32'h44332211, 5'd0, 1'b1, 8'h44, 8'h00, 8'h00, 8'h00}, // R5
    '{4'd4,  3'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 32'h00000004, 5'd2, 1'b1, 8'h01, 8'h00, 8'h00, 8'h00}, // R4
    '{4'd6,  3'd0, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 32'h00000080, 5'd0, 1'b1, 8'h01, 8'h00, 8'h00, 8'h00}, // R6
    '{4'd5,  3'd0, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 32'h80000000, 5'd0, 1'b1, 8'h01, 8'h00, 8'h00, 8'h00}, // R5 priority
    '{4'd6,  3'd2, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 32'h000000A5, 5'd0, 1'b1, 8'h0A, 8'h00, 8'h00, 8'h00}, // R6
    '{4'd6,  3'd3, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 32'h44332211, 5'd1, 1'b1, 8'h22, 8'h00, 8'h00, 8'h00}, // R6 no effect
    '{4'd8,  3'd4, 1'b0, 1'b0, 1'b0, 2'd2, 1'b0, 32'h0000ABCD, 5'd0, 1'b0, 8'h00, 8'h68, 8'h78, 8'hA8}, // R8
    '{4'd8,  3'd4, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0000ABCD, 5'd0, 1'b0, 8'h00, 8'hA8, 8'h78, 8'h68}, // R8 swap
    '{4'd10, 3'd4, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 32'h0000ABCD, 5'd0, 1'b0, 8'h00, 8'hA8, 8'h78, 8'h68}, // R10 forced
    '{4'd9,  3'd4, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0, 32'h0000ABCD, 5'd0, 1'b0, 8'h00, 8'h50, 8'hF0, 8'h68}, // R9
    '{4'd9,  3'd4, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 32'h00002BCD, 5'd0, 1'b0, 8'h00, 8'h68, 8'hF0, 8'h50}, // R9 bit15
    '{4'd10, 3'd4, 1'b0, 1'b0, 1'b0, 2'd3, 1'b1, 32'h0000ABCD, 5'd0, 1'b0, 8'h00, 8'h68, 8'hF0, 8'h50}, // R10 native
    '{4'd10, 3'd6, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, 32'hABCD0000, 5'd1, 1'b0, 8'h00, 8'h68, 8'h78, 8'hA8}, // R10 code 6
    '{4'd11, 3'd7, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 32'h0000F321, 5'd0, 1'b0, 8'h00, 8'h10, 8'h20, 8'h30}, // R11
    '{4'd11, 3'd7, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 32'h0000F321, 5'd0, 1'b0, 8'h00, 8'h30, 8'h20, 8'h10}, // R11 swap
    '{4'd12, 3'd5, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 32'hFF332211, 5'd0, 1'b0, 8'h00, 8'h11, 8'h22, 8'h33}, // R12
    '{4'd12, 3'd5, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 32'hFF332211, 5'd0, 1'b0, 8'h00, 8'h33, 8'h22, 8'h11}, // R12 swap
    '{4'd5,  3'd4, 1'b0, 1'b1, 1'b0, 2'd2, 1'b0, 32'hABCD0000, 5'd0, 1'b0, 8'h00, 8'h68, 8'h78, 8'hA8}, // R5 16-bit
    '{4'd6,  3'd4, 1'b0, 1'b0, 1'b1, 2'd2, 1'b0, 32'h0000ABCD, 5'd0, 1'b0, 8'h00, 8'h68, 8'h78, 8'hA8}, // R6 16-bit
    '{4'd4,  3'd2, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 32'h000000A5, 5'd1, 1'b1, 8'h0A, 8'h00, 8'h00, 8'h00}, // R4
    '{4'd11, 3'd7, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 32'h00005321, 5'd0, 1'b0, 8'h00, 8'h10, 8'h20, 8'h30}  // R11 top ignored
  };

  function automatic int pix_per_word(logic [2:0] dep);
    case (dep)
      3'd0: return 32;
      3'd1: return 16;
      3'd2: return 8;
      3'd3: return 4;
      3'd5: return 1;
      default: return 2;
    endcase
  endfunction

  task automatic run_vec(input vec_t v);
    string tag;
    int    n;
    logic  c_ind;
    logic [7:0] c_idx, c_r, c_g, c_b;
    tag = $sformatf("R%0d", v.req);
    n   = pix_per_word(v.dep);
    c_ind = 1'bx; c_idx = 'x; c_r = 'x; c_g = 'x; c_b = 'x;
    @(negedge clk);
    ctl_en = 1'b1; ctl_power = 1'b1; ctl_depth = v.dep; ctl_bgr = v.bgr;
    ctl_be_byte = v.bb; ctl_be_pix = v.bp; mux_sel = v.mux; native565 = v.nat;
    in_word = v.word; in_valid = 1'b1; out_ready = 1'b1;
    #1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R3", "out_valid one cycle after accept", 32'(out_valid), 32'd1);
    for (int p = 0; p < n; p++) begin
      if (p == int'(v.k)) begin
        c_ind = out_indexed; c_idx = out_index; c_r = out_r; c_g = out_g; c_b = out_b;
      end
      @(negedge clk);
    end
    chk("R2", "out_valid low after last pixel", 32'(out_valid), 32'd0);
    chk("R2", "in_ready back after last pixel", 32'(in_ready), 32'd1);
    chk(tag, "indexed flag", 32'(c_ind), 32'(v.ind));
    chk(tag, "index", 32'(c_idx), 32'(v.idx));
    chk(tag, "red", 32'(c_r), 32'(v.r));
    chk(tag, "green", 32'(c_g), 32'(v.g));
    chk(tag, "blue", 32'(c_b), 32'(v.b));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R14", "out_valid during reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R14", "out_valid after reset", 32'(out_valid), 32'd0);
    chk("R14", "in_ready after reset", 32'(in_ready), 32'd1);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R1: power off, enable off, illegal code
    @(negedge clk);
    ctl_depth = 3'd3; ctl_bgr = 0; ctl_be_byte = 0; ctl_be_pix = 0; native565 = 0;
    ctl_power = 1'b0; in_valid = 1'b1; in_word = 32'h44332211; out_ready = 1'b1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R1", "in_ready with power off", 32'(in_ready), 32'd0);
      chk("R1", "out_valid with power off", 32'(out_valid), 32'd0);
    end
    ctl_power = 1'b1; ctl_en = 1'b0;
    @(negedge clk);
    chk("R1", "in_ready with enable off", 32'(in_ready), 32'd0);
    ctl_en = 1'b1; ctl_depth = 3'd6;
    @(negedge clk);
    chk("R1", "in_ready with code 6 non-native", 32'(in_ready), 32'd0);
    chk("R1", "out_valid with code 6 non-native", 32'(out_valid), 32'd0);
    ctl_depth = 3'd7;
    @(negedge clk);
    chk("R1", "in_ready with code 7 non-native", 32'(in_ready), 32'd0);
    in_valid = 1'b0; ctl_depth = 3'd3;

    // R3: stall holds the pixel and blocks input
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_word = 32'h44332211;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    for (int c = 0; c < 3; c++) begin
      chk("R3", "stalled out_valid", 32'(out_valid), 32'd1);
      chk("R3", "stalled pixel", 32'(out_index), 32'h11);
      chk("R3", "stalled in_ready", 32'(in_ready), 32'd0);
      @(negedge clk);
    end
    // R1: disabling drops the held word
    ctl_en = 1'b0;
    @(negedge clk);
    ctl_en = 1'b1;
    #1;
    chk("R1", "out_valid after drop", 32'(out_valid), 32'd0);
    chk("R1", "in_ready after drop", 32'(in_ready), 32'd1);
    out_ready = 1'b1;

    // R13: bytes per line for 640 columns
    line_cols = 12'd640;
    for (int d = 0; d < 8; d++) begin
      int exp_lb;
      ctl_depth = 3'(d);
      case (d)
        0: exp_lb = 80;
        1: exp_lb = 160;
        2: exp_lb = 320;
        3: exp_lb = 640;
        5: exp_lb = 2560;
        default: exp_lb = 1280;
      endcase
      #1;
      chk("R13", $sformatf("line bytes code %0d", d), 32'(line_bytes), 32'(exp_lb));
    end

    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule